// File: doc/BRIEF.md
# Processor Power Mode Controller

This block chooses the power state of a processor core and drives one clock enable for each functional unit. After reset the core runs in full power. Software writes a global power-enable bit, a dynamic-gating bit and a one-hot low-power select field. In full power with dynamic gating on, any unit that reports itself idle loses its clock enable. Dynamic gating never changes what software can observe.

When the stored global bit is set and the select field names the doze mode, the controller enters doze. In doze only the timer unit and the bus-snoop unit stay clocked. The clock generator is assumed to stay locked, so leaving doze needs only a short, fixed count of cycles. Six wake lines end doze: external interrupt, system-management interrupt, decrementer exception, hard reset request, soft reset request and machine check. When the resume count runs out, every clock enable is restored and a one-cycle completion pulse is raised. The global bit is cleared on wake, so the core does not fall straight back into doze.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `mode_o` is 0 (full power), `unit_clk_en_o` is all ones, `wake_done_o` is 0 and `pm_en_o` is 0.
- R2: In full power with the stored dynamic-gating bit at 0, every bit of `unit_clk_en_o` is 1, whatever `unit_idle_i` holds.
- R3: In full power with the stored dynamic-gating bit at 1, bit i of `unit_clk_en_o` is the inverse of `unit_idle_i[i]` as sampled at the previous clock edge.
- R4: At the clock edge after a control write that stores global bit 1 and select value 3'b001 (bit 0 = doze), with no wake line high at that edge, the controller enters doze. `mode_o` becomes 1 and `unit_clk_en_o` becomes 8'hC0, so only unit 6 (timer) and unit 7 (snoop) are enabled. `unit_idle_i` has no effect in doze.
- R5: Doze is not entered if the stored global bit is 0, or if the stored select value is anything other than exactly 3'b001. This covers zero, the other single bits and several bits set at once.
- R6: Any one of the six bits of `wake_i` that is high at a clock edge in doze moves the controller to resume at that edge (`mode_o` = 2). The enables stay at the doze mask during resume.
- R7: RESUME_CYC clock edges after the wake edge (default 4), `mode_o` returns to 0, `unit_clk_en_o` is restored to its full-power value, and `wake_done_o` is high for exactly that one cycle.
- R8: The wake edge clears the stored global bit, so `pm_en_o` reads 0 from resume onward.
- R9: If a wake line is high at the edge where a doze request is evaluated, entry is cancelled. `mode_o` stays 0 and the global bit is cleared.
- R10: Control writes are ignored outside full power. Wake lines are ignored during resume and do not lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_pwr_en_i | input | 1 | Global power-enable bit to store |
| ctl_dyn_en_i | input | 1 | Dynamic idle gating bit to store |
| ctl_sel_i | input | 3 | Low-power select, one-hot; bit 0 = doze |
| unit_idle_i | input | 8 | Per-unit idle flags |
| wake_i | input | 6 | Wake event lines |
| unit_clk_en_o | output | 8 | Per-unit clock enables; bit 6 timer, bit 7 snoop |
| mode_o | output | 2 | 0 full power, 1 doze, 2 resume |
| pm_en_o | output | 1 | Current stored global power-enable bit |
| wake_done_o | output | 1 | One-cycle pulse when full power is restored |

## Verification
Every result is registered, so it appears one edge after the inputs that cause it. A doze request shows in `mode_o` one edge after the write edge. A wake shows as resume at the edge it is sampled, and full power plus `wake_done_o` appear RESUME_CYC edges later. Idle-driven gating lags `unit_idle_i` by one edge. The bench drives inputs on the falling edge, steps whole clock cycles and samples on the next falling edge, counting edges to match these latencies. It also samples one edge before the resume ends and one edge after the pulse, to pin the exact cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_FULL   = 2'd0,
        PM_DOZE   = 2'd1,
        PM_RESUME = 2'd2
    } pm_mode_e;

endpackage

// File: rtl/pwr_wake_merge.sv
module pwr_wake_merge #(
    parameter int                     NUM_WAKE  = 6,
    parameter logic [NUM_WAKE-1:0]    WAKE_MASK = '1
) (
    input  logic [NUM_WAKE-1:0] wake_i,
    output logic                wake_any_o
);

    logic [NUM_WAKE-1:0] wake_masked;

    for (genvar w = 0; w < NUM_WAKE; w++) begin : g_src
        if (WAKE_MASK[w]) begin : g_on
            assign wake_masked[w] = wake_i[w];
        end else begin : g_off
            assign wake_masked[w] = 1'b0;
        end
    end

    assign wake_any_o = |wake_masked;

endmodule

// File: rtl/pwr_resume_timer.sv
module pwr_resume_timer #(
    parameter int RESUME_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic active_i,
    output logic expire_o
);

    localparam int             CW   = $clog2(RESUME_CYC + 1);
    localparam logic [CW-1:0]  LAST = CW'(RESUME_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(1);
        end else if (active_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = active_i && (cnt_q == LAST);

    // R7: the resume count never runs past its terminal value
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: a running resume count is always at least one
    assert_cnt_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (cnt_q != '0));

endmodule

// File: rtl/pwr_clk_en_gen.sv
module pwr_clk_en_gen #(
    parameter int NUM_UNITS = 8,
    parameter int TIMER_IDX = 6,
    parameter int SNOOP_IDX = 7
) (
    input  logic                 dyn_en_i,
    input  logic [NUM_UNITS-1:0] idle_i,
    output logic [NUM_UNITS-1:0] full_en_o,
    output logic [NUM_UNITS-1:0] doze_en_o
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam bit KEEP = (u == TIMER_IDX) || (u == SNOOP_IDX);

        assign full_en_o[u] = dyn_en_i ? ~idle_i[u] : 1'b1;

        if (KEEP) begin : g_keep
            assign doze_en_o[u] = 1'b1;
        end else begin : g_stop
            assign doze_en_o[u] = 1'b0;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int NUM_UNITS  = 8,
    parameter int NUM_WAKE   = 6,
    parameter int NUM_SEL    = 3,
    parameter int TIMER_IDX  = 6,
    parameter int SNOOP_IDX  = 7,
    parameter int RESUME_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr_i,
    input  logic                 ctl_pwr_en_i,
    input  logic                 ctl_dyn_en_i,
    input  logic [NUM_SEL-1:0]   ctl_sel_i,
    input  logic [NUM_UNITS-1:0] unit_idle_i,
    input  logic [NUM_WAKE-1:0]  wake_i,
    output logic [NUM_UNITS-1:0] unit_clk_en_o,
    output logic [1:0]           mode_o,
    output logic                 pm_en_o,
    output logic                 wake_done_o
);
    import pwr_mode_pkg::*;

    localparam logic [NUM_SEL-1:0] DOZE_SEL = NUM_SEL'(1);

    typedef struct packed {
        pm_mode_e               mode;
        logic                   pwr_en;
        logic                   dyn_en;
        logic [NUM_SEL-1:0]     sel;
        logic [NUM_UNITS-1:0]   clk_en;
        logic                   done;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    logic                 wake_any;
    logic                 doze_req;
    logic                 timer_start;
    logic                 timer_expire;
    logic                 in_resume;
    logic [NUM_UNITS-1:0] full_en;
    logic [NUM_UNITS-1:0] doze_en;

    assign in_resume = (s_q.mode == PM_RESUME);

    pwr_wake_merge #(
        .NUM_WAKE (NUM_WAKE)
    ) u_wake (
        .wake_i     (wake_i),
        .wake_any_o (wake_any)
    );

    pwr_resume_timer #(
        .RESUME_CYC (RESUME_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (timer_start),
        .active_i (in_resume),
        .expire_o (timer_expire)
    );

    pwr_clk_en_gen #(
        .NUM_UNITS (NUM_UNITS),
        .TIMER_IDX (TIMER_IDX),
        .SNOOP_IDX (SNOOP_IDX)
    ) u_en_gen (
        .dyn_en_i  (s_q.dyn_en),
        .idle_i    (unit_idle_i),
        .full_en_o (full_en),
        .doze_en_o (doze_en)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        timer_start = 1'b0;
        doze_req    = s_q.pwr_en && (s_q.sel == DOZE_SEL);

        case (s_q.mode)
            PM_FULL: begin
                if (ctl_wr_i) begin
                    s_d.pwr_en = ctl_pwr_en_i;
                    s_d.dyn_en = ctl_dyn_en_i;
                    s_d.sel    = ctl_sel_i;
                end
                if (doze_req) begin
                    if (wake_any) begin
                        s_d.pwr_en = 1'b0;
                    end else begin
                        s_d.mode = PM_DOZE;
                    end
                end
            end
            PM_DOZE: begin
                if (wake_any) begin
                    s_d.mode    = PM_RESUME;
                    s_d.pwr_en  = 1'b0;
                    timer_start = 1'b1;
                end
            end
            PM_RESUME: begin
                if (timer_expire) begin
                    s_d.mode = PM_FULL;
                    s_d.done = 1'b1;
                end
            end
            default: begin
                s_d.mode = PM_FULL;
            end
        endcase

        s_d.clk_en = (s_d.mode == PM_FULL) ? full_en : doze_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode   <= PM_FULL;
            s_q.pwr_en <= 1'b0;
            s_q.dyn_en <= 1'b0;
            s_q.sel    <= '0;
            s_q.clk_en <= '1;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign unit_clk_en_o = s_q.clk_en;
    assign mode_o        = s_q.mode;
    assign pm_en_o       = s_q.pwr_en;
    assign wake_done_o   = s_q.done;

    // R2: without dynamic gating, a steady full-power state keeps all units on
    assert_full_all_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_FULL && $past(s_q.mode) == PM_FULL &&
         !s_q.dyn_en && !$past(s_q.dyn_en)) |-> (unit_clk_en_o == '1));

    // R4: doze keeps only the timer and snoop enables
    assert_doze_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_DOZE) |-> (unit_clk_en_o == doze_en));

    // R5: doze is reached only from a valid, uncontested request
    assert_entry_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_DOZE && $past(s_q.mode) == PM_FULL) |->
        $past(s_q.pwr_en && (s_q.sel == DOZE_SEL) && !wake_any));

    // R6: a wake in doze starts resume on the next cycle
    assert_wake_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_DOZE && wake_any) |=> (s_q.mode == PM_RESUME));

    // R7: completion pulse lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R7: completion pulse marks the first full-power cycle after resume
    assert_done_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.mode == PM_FULL && $past(s_q.mode) == PM_RESUME));

    // R8: the global bit is clear throughout resume
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_RESUME) |-> !s_q.pwr_en);

    // R9: a coincident wake cancels doze entry
    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_FULL && doze_req && wake_any) |=>
        (s_q.mode == PM_FULL && !s_q.pwr_en));

    // R10: writes leave the stored control unchanged in doze
    assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == PM_DOZE && !wake_any) |=> $stable(s_q.dyn_en) && $stable(s_q.sel));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    localparam int RESUME_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_i = 1'b0;
    logic       ctl_pwr_en_i = 1'b0;
    logic       ctl_dyn_en_i = 1'b0;
    logic [2:0] ctl_sel_i = 3'b000;
    logic [7:0] unit_idle_i = 8'hFF;
    logic [5:0] wake_i = 6'b0;
    logic [7:0] unit_clk_en_o;
    logic [1:0] mode_o;
    logic       pm_en_o;
    logic       wake_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.RESUME_CYC(RESUME_CYC)) i_pwr_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_wr_i      (ctl_wr_i),
        .ctl_pwr_en_i  (ctl_pwr_en_i),
        .ctl_dyn_en_i  (ctl_dyn_en_i),
        .ctl_sel_i     (ctl_sel_i),
        .unit_idle_i   (unit_idle_i),
        .wake_i        (wake_i),
        .unit_clk_en_o (unit_clk_en_o),
        .mode_o        (mode_o),
        .pm_en_o       (pm_en_o),
        .wake_done_o   (wake_done_o)
    );

    // {dyn, idle[7:0], expected enables[7:0]}
    localparam logic [16:0] VEC [7] = '{
        {1'b0, 8'hFF, 8'hFF},
        {1'b0, 8'h00, 8'hFF},
        {1'b1, 8'hFF, 8'h00},
        {1'b1, 8'h0F, 8'hF0},
        {1'b1, 8'hA5, 8'h5A},
        {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h3C, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic pe, input logic dyn, input logic [2:0] sel);
        ctl_wr_i = 1'b1; ctl_pwr_en_i = pe; ctl_dyn_en_i = dyn; ctl_sel_i = sel;
        step();
        ctl_wr_i = 1'b0;
    endtask

    task automatic wake_and_finish(input int idx);
        wake_i = 6'(1 << idx);
        step();
        wake_i = '0;
        chk("R6 resume mode", 32'(mode_o), 32'd2);
        chk("R6 resume enables", 32'(unit_clk_en_o), 32'hC0);
        chk("R8 global bit cleared", 32'(pm_en_o), 32'd0);
        repeat (RESUME_CYC - 1) step();
        chk("R7 still resuming", 32'(mode_o), 32'd2);
        chk("R7 no early pulse", 32'(wake_done_o), 32'd0);
        step();
        chk("R7 full power restored", 32'(mode_o), 32'd0);
        chk("R7 done pulse", 32'(wake_done_o), 32'd1);
        chk("R7 enables restored", 32'(unit_clk_en_o), 32'hFF);
        step();
        chk("R7 pulse one cycle", 32'(wake_done_o), 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mode", 32'(mode_o), 32'd0);
        chk("R1 reset enables", 32'(unit_clk_en_o), 32'hFF);
        rst_n = 1'b1;
        chk("R1 first cycle enables", 32'(unit_clk_en_o), 32'hFF);
        chk("R1 first cycle done", 32'(wake_done_o), 32'd0);
        chk("R1 first cycle global bit", 32'(pm_en_o), 32'd0);

        // table walk: dynamic gating in full power (R2, R3)
        foreach (VEC[i]) begin
            unit_idle_i = VEC[i][15:8];
            write_ctl(1'b0, VEC[i][16], 3'b000);
            step();
            chk(VEC[i][16] ? "R3 gated enables" : "R2 ungated enables",
                32'(unit_clk_en_o), 32'(VEC[i][7:0]));
            chk("R2 stays full", 32'(mode_o), 32'd0);
        end

        // R3: one-edge latency on idle changes
        write_ctl(1'b0, 1'b1, 3'b000);
        unit_idle_i = 8'h00;
        step();
        unit_idle_i = 8'hF0;
        chk("R3 before idle edge", 32'(unit_clk_en_o), 32'hFF);
        step();
        chk("R3 after idle edge", 32'(unit_clk_en_o), 32'h0F);

        unit_idle_i = 8'hFF;
        write_ctl(1'b0, 1'b0, 3'b000);
        step();

        // R5: invalid selects or disabled global bit never enter doze
        foreach (VEC[i]) begin
            if (i < 4) begin
                logic [2:0] s;
                s = (i == 0) ? 3'b010 : (i == 1) ? 3'b011 : (i == 2) ? 3'b100 : 3'b000;
                write_ctl(1'b1, 1'b0, s);
                step();
                step();
                chk("R5 invalid select stays full", 32'(mode_o), 32'd0);
            end
        end
        write_ctl(1'b0, 1'b0, 3'b001);
        step();
        chk("R5 global bit off stays full", 32'(mode_o), 32'd0);

        // R4 entry and R6/R7/R8 wake, once per wake line
        for (int k = 0; k < 6; k++) begin
            write_ctl(1'b1, 1'b0, 3'b001);
            step();
            chk("R4 doze mode", 32'(mode_o), 32'd1);
            chk("R4 doze enables", 32'(unit_clk_en_o), 32'hC0);
            chk("R4 global bit held", 32'(pm_en_o), 32'd1);
            wake_and_finish(k);
        end

        // R9: wake coincident with the request cancels entry
        write_ctl(1'b1, 1'b0, 3'b001);
        wake_i = 6'b000100;
        step();
        wake_i = '0;
        chk("R9 cancel stays full", 32'(mode_o), 32'd0);
        chk("R9 global bit cleared", 32'(pm_en_o), 32'd0);
        step();
        chk("R9 no late entry", 32'(mode_o), 32'd0);

        // R4 idle ignored in doze, R10 writes and resume wakes ignored
        write_ctl(1'b1, 1'b0, 3'b001);
        step();
        unit_idle_i = 8'h00;
        step();
        chk("R4 idle ignored in doze", 32'(unit_clk_en_o), 32'hC0);
        write_ctl(1'b1, 1'b1, 3'b001);
        chk("R10 doze kept after write", 32'(mode_o), 32'd1);
        unit_idle_i = 8'hFF;
        wake_i = 6'b100000;
        step();
        chk("R6 machine-check wake", 32'(mode_o), 32'd2);
        wake_i = 6'b000001;
        step();
        wake_i = '0;
        step();
        step();
        chk("R10 resume not extended", 32'(mode_o), 32'd2);
        step();
        chk("R10 resume ends on time", 32'(mode_o), 32'd0);
        chk("R10 write ignored: dyn off", 32'(unit_clk_en_o), 32'hFF);
        chk("R10 write ignored: global bit", 32'(pm_en_o), 32'd0);
        step();
        chk("R10 no re-entry", 32'(mode_o), 32'd0);

        finish_run();
    end

endmodule